// File: doc/BRIEF.md
# Timed Address-Event Command Sequencer

This block plays back a host-prepared stream of commands as address events. It reads 18-bit words from a first-word-fall-through FIFO whenever the FIFO holds data. The upper two bits of each word are an opcode and the lower sixteen bits are its data. Depending on the opcode, the sequencer does one of four things:

- drives an address event on a four-phase request/acknowledge output;
- waits a given number of slow time ticks;
- waits until a free-running 32-bit time value reaches a target that is spread over two words;
- stops.

Generated events are injected on one of several arbiter input channels. A selector input chooses the channel, so the sequencer looks to the arbiter like one more sender chip.

Two sticky interrupt flags help the host keep the stream fed. One rises when the FIFO runs dry. The other rises when the FIFO occupancy falls below half.

Top module: `aer_seq_engine`

## Requirements
- R1: A command word has its opcode in bits 17:16 and its data in bits 15:0. `fifo_rd` is asserted only while `fifo_empty` is low. Each single-word command consumes exactly one word.
- R2: Opcode 01 drives `ev_addr` with the 16-bit data. It raises the `ev_req` bit whose index equals `chan_sel`, and only that bit. Both are held until `ev_ack` is high. `ev_req` then drops, and the next word is read only after `ev_ack` has returned low.
- R3: Opcode 10 with data N>0 suspends reading until N pulses of `tick` have been counted. The following command then executes.
- R4: Opcode 10 with data 0 completes without any `tick`.
- R5: Opcode 11 takes its data as the upper 16 bits of a target time. The next word supplies the lower 16 bits, and the opcode bits of that second word are ignored. Execution resumes once `now_time` is greater than or equal to the target.
- R6: An absolute wait whose target is not later than `now_time` completes without any change of `now_time`.
- R7: If the FIFO is empty when the second word of an absolute wait is needed, the sequencer waits for that word without emitting anything.
- R8: Opcode 00 ends the sequence. No further word is read until `enable` goes low and then high again. Going from low to high on `enable` is also what starts a sequence after reset.
- R9: `irq_empty` sets on the cycle after the FIFO turns from non-empty to empty. It stays set until `irq_clr` is pulsed.
- R10: `irq_half` sets on the cycle after `fifo_half` falls from 1 to 0. It stays set until `irq_clr` is pulsed.
- R11: During and right after reset, `ev_req` is all zero, `fifo_rd` is low, and both interrupt flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; a rising edge starts a sequence |
| fifo_empty | input | 1 | Command FIFO holds no word |
| fifo_half | input | 1 | Command FIFO occupancy is at least half |
| fifo_rdata | input | 18 | Head word of the command FIFO |
| fifo_rd | output | 1 | Pop the head word this cycle |
| tick | input | 1 | One-cycle pulse of the slow time base |
| now_time | input | 32 | Current absolute time |
| chan_sel | input | 2 | Channel on which events are injected |
| ev_req | output | 4 | Per-channel event request |
| ev_addr | output | 16 | Event label |
| ev_ack | input | 1 | Acknowledge from the selected channel |
| irq_clr | input | 1 | Clears both interrupt flags |
| irq_empty | output | 1 | Sticky flag: FIFO ran empty |
| irq_half | output | 1 | Sticky flag: occupancy fell below half |

## Verification
The hardest case to reach is an absolute wait whose second word is still missing. In that state an absent word, a wrong tag decode or a premature resume all look alike from outside: nothing happens. The bench gets there by pushing only the first word of the pair. After a long pause, it supplies the lower half with a delay opcode while no ticks are running. A spike that follows only appears if that word was taken as time data. Delay lengths are swept with ticks released one at a time, so the exact tick that releases the next event is pinned down.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    OP_END   = 2'b00,
    OP_SPIKE = 2'b01,
    OP_DELAY = 2'b10,
    OP_ABS   = 2'b11
  } op_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EMIT,
    S_RELEASE,
    S_DELAY,
    S_ABS_LO,
    S_ABS_WAIT
  } state_t;

endpackage

// File: rtl/seq_tick_count.sv
module seq_tick_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/seq_fall_flag.sv
module seq_fall_flag (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic clr,
  output logic flag
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      level_q <= level;
      if (level_q && !level) begin
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seq_chan_decode.sv
module seq_chan_decode #(
  parameter int CH_N = 4,
  parameter int CH_W = 2
) (
  input  logic [CH_W-1:0] sel,
  output logic [CH_N-1:0] onehot
);
  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    assign onehot[i] = (sel == CH_W'(i));
  end
endmodule

// File: rtl/aer_seq_engine.sv
module aer_seq_engine #(
  parameter int DATA_W = 16,
  parameter int CH_N   = 4,
  localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int WORD_W = DATA_W + 2,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  input  logic              tick,
  input  logic [TIME_W-1:0] now_time,
  input  logic [CH_W-1:0]   chan_sel,
  output logic [CH_N-1:0]   ev_req,
  output logic [DATA_W-1:0] ev_addr,
  input  logic              ev_ack,
  input  logic              irq_clr,
  output logic              irq_empty,
  output logic              irq_half
);
  import seq_pkg::*;

  state_t              state;
  logic                en_q;
  logic [DATA_W-1:0]   hi_q;
  logic [TIME_W-1:0]   target_q;
  logic [CH_N-1:0]     sel_oh;
  logic                dly_zero;
  logic                dly_load;
  op_t                 op;
  logic [DATA_W-1:0]   data;

  assign op   = op_t'(fifo_rdata[WORD_W-1 -: 2]);
  assign data = fifo_rdata[DATA_W-1:0];

  always_comb begin
    fifo_rd = !fifo_empty &&
              ((state == S_FETCH && enable) || state == S_ABS_LO);
  end

  assign dly_load = fifo_rd && (state == S_FETCH) && (op == OP_DELAY);

  seq_chan_decode #(.CH_N(CH_N), .CH_W(CH_W)) u_dec (
    .sel    (chan_sel),
    .onehot (sel_oh)
  );

  seq_tick_count #(.W(DATA_W)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_load),
    .load_val (data),
    .tick     (tick),
    .zero     (dly_zero)
  );

  seq_fall_flag u_irq_empty (
    .clk   (clk),
    .rst   (rst),
    .level (!fifo_empty),
    .clr   (irq_clr),
    .flag  (irq_empty)
  );

  seq_fall_flag u_irq_half (
    .clk   (clk),
    .rst   (rst),
    .level (fifo_half),
    .clr   (irq_clr),
    .flag  (irq_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      en_q     <= 1'b0;
      ev_req   <= '0;
      ev_addr  <= '0;
      hi_q     <= '0;
      target_q <= '0;
    end else begin
      en_q <= enable;
      case (state)
        S_IDLE: begin
          if (enable && !en_q) state <= S_FETCH;
        end
        S_FETCH: begin
          if (!enable) begin
            state <= S_IDLE;
          end else if (!fifo_empty) begin
            case (op)
              OP_END:   state <= S_IDLE;
              OP_SPIKE: begin
                ev_addr <= data;
                ev_req  <= sel_oh;
                state   <= S_EMIT;
              end
              OP_DELAY: state <= S_DELAY;
              OP_ABS: begin
                hi_q  <= data;
                state <= S_ABS_LO;
              end
              default:  state <= S_IDLE;
            endcase
          end
        end
        S_EMIT: begin
          if (ev_ack) begin
            ev_req <= '0;
            state  <= S_RELEASE;
          end
        end
        S_RELEASE: begin
          if (!ev_ack) state <= S_FETCH;
        end
        S_DELAY: begin
          if (dly_zero) state <= S_FETCH;
        end
        S_ABS_LO: begin
          if (!fifo_empty) begin
            target_q <= {hi_q, data};
            state    <= S_ABS_WAIT;
          end
        end
        S_ABS_WAIT: begin
          if (now_time >= target_q) state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aer_seq_engine_chk.sv
module aer_seq_engine_chk #(
  parameter int CH_N = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            fifo_empty,
  input logic            fifo_half,
  input logic            fifo_rd,
  input logic [CH_N-1:0] ev_req,
  input logic [15:0]     ev_addr,
  input logic            ev_ack,
  input logic            irq_clr,
  input logic            irq_empty,
  input logic            irq_half
);
  a_r1_rd_nonempty: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  a_r2_req_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev_req));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_req != '0 && !ev_ack) |=> ($stable(ev_req) && $stable(ev_addr)));

  a_r2_req_drop: assert property (@(posedge clk) disable iff (rst)
    (ev_req != '0 && ev_ack) |=> (ev_req == '0));

  a_r9_empty_set: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_empty) |=> irq_empty);

  a_r9_empty_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_empty && !irq_clr) |=> irq_empty);

  a_r10_half_set: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_half) |=> irq_half);

  a_r10_half_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_half && !irq_clr) |=> irq_half);
endmodule

bind aer_seq_engine aer_seq_engine_chk #(.CH_N(CH_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_empty (fifo_empty),
  .fifo_half  (fifo_half),
  .fifo_rd    (fifo_rd),
  .ev_req     (ev_req),
  .ev_addr    (ev_addr),
  .ev_ack     (ev_ack),
  .irq_clr    (irq_clr),
  .irq_empty  (irq_empty),
  .irq_half   (irq_half)
);

// File: tb/aer_seq_engine_test.sv
`timescale 1ns/1ps
module aer_seq_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] now_time = '0;
  logic [1:0]  chan_sel = '0;
  logic        ev_ack = 1'b0;
  logic        irq_clr = 1'b0;
  logic        fifo_rd;
  logic [3:0]  ev_req;
  logic [15:0] ev_addr;
  logic        irq_empty, irq_half;
  logic        fifo_empty, fifo_half;
  logic [17:0] fifo_rdata;

  logic [17:0] mem [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [3:0]  rec_req [0:255];
  logic [15:0] rec_addr [0:255];
  int ev_cnt = 0;
  logic [3:0] req_prev = '0;

  always #2.5 clk = ~clk;

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_half  = ((wr_ptr - rd_ptr) >= 4);
  assign fifo_rdata = mem[rd_ptr % 64];

  aer_seq_engine uut (
    .clk(clk), .rst(rst), .enable(enable), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
    .tick(tick), .now_time(now_time), .chan_sel(chan_sel), .ev_req(ev_req),
    .ev_addr(ev_addr), .ev_ack(ev_ack), .irq_clr(irq_clr),
    .irq_empty(irq_empty), .irq_half(irq_half)
  );

  always @(posedge clk) begin
    if (fifo_rd) rd_ptr <= rd_ptr + 1;
    ev_ack   <= |ev_req;
    req_prev <= ev_req;
    if (ev_req != '0 && req_prev == '0 && ev_cnt < 256) begin
      rec_req[ev_cnt]  <= ev_req;
      rec_addr[ev_cnt] <= ev_addr;
      ev_cnt           <= ev_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    mem[wr_ptr % 64] = {op, d};
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    int base;
    logic [15:0] lbl;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(ev_req == 4'b0, "R11 req", ev_req, 0);
    chk(fifo_rd == 1'b0, "R11 rd", fifo_rd, 0);
    chk(irq_empty == 1'b0 && irq_half == 1'b0, "R11 irq", {irq_empty, irq_half}, 0);

    enable = 1'b1;
    wait_cyc(2);

    // R2 channel and label sweep; R1 one pop per word
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 3; k++) begin
        lbl = (16'h1111 * ch) ^ (16'h0F0F * k) ^ 16'h8001;
        @(negedge clk); chan_sel = ch[1:0];
        base = ev_cnt;
        push(2'b01, lbl);
        wait_cyc(12);
        chk(ev_cnt == base + 1, "R2 count", ev_cnt, base + 1);
        chk(rec_req[base] == (4'b1 << ch), "R2 channel", rec_req[base], 4'b1 << ch);
        chk(rec_addr[base] == lbl, "R2 label", rec_addr[base], lbl);
        chk(wr_ptr == rd_ptr, "R1 pop", wr_ptr - rd_ptr, 0);
      end
    end

    // R3 / R4 delay sweep
    for (int n = 0; n < 6; n++) begin
      base = ev_cnt;
      push(2'b01, 16'hA000 + n);
      push(2'b10, n[15:0]);
      push(2'b01, 16'hB000 + n);
      wait_cyc(20);
      if (n == 0) begin
        chk(ev_cnt == base + 2, "R4 zero delay", ev_cnt, base + 2);
      end else begin
        chk(ev_cnt == base + 1, "R3 held", ev_cnt, base + 1);
        for (int k = 1; k <= n; k++) begin
          pulse_tick();
          wait_cyc(8);
          chk(ev_cnt == base + ((k == n) ? 2 : 1), "R3 tick count", ev_cnt,
              base + ((k == n) ? 2 : 1));
        end
      end
      chk(rec_addr[base + 1] == 16'hB000 + n, "R3 label", rec_addr[base + 1], 16'hB000 + n);
    end

    // R5 absolute wait, second word tag ignored
    @(negedge clk); now_time = 32'h0001_03F0;
    base = ev_cnt;
    push(2'b11, 16'h0001);
    push(2'b01, 16'h0400);
    push(2'b01, 16'h5A5A);
    wait_cyc(20);
    chk(ev_cnt == base, "R5 early", ev_cnt, base);
    chk(wr_ptr - rd_ptr == 1, "R5 pending word", wr_ptr - rd_ptr, 1);
    @(negedge clk); now_time = 32'h0001_03FF;
    wait_cyc(10);
    chk(ev_cnt == base, "R5 one before", ev_cnt, base);
    @(negedge clk); now_time = 32'h0001_0400;
    wait_cyc(12);
    chk(ev_cnt == base + 1, "R5 resume", ev_cnt, base + 1);
    chk(rec_addr[base] == 16'h5A5A, "R5 label", rec_addr[base], 16'h5A5A);

    // R6 target already passed
    @(negedge clk); now_time = 32'h0002_0000;
    base = ev_cnt;
    push(2'b11, 16'h0001);
    push(2'b00, 16'h0000);
    push(2'b01, 16'h1234);
    wait_cyc(14);
    chk(ev_cnt == base + 1, "R6 past target", ev_cnt, base + 1);
    chk(rec_addr[base] == 16'h1234, "R6 label", rec_addr[base], 16'h1234);

    // R7 stall for missing second word
    base = ev_cnt;
    push(2'b11, 16'h0000);
    wait_cyc(25);
    chk(ev_cnt == base, "R7 stall quiet", ev_cnt, base);
    push(2'b10, 16'h0005);
    push(2'b01, 16'h7777);
    wait_cyc(14);
    chk(ev_cnt == base + 1, "R7 resume", ev_cnt, base + 1);
    chk(rec_addr[base] == 16'h7777, "R7 label", rec_addr[base], 16'h7777);

    // R8 end of sequence
    base = ev_cnt;
    push(2'b01, 16'h0A0A);
    push(2'b00, 16'h0000);
    push(2'b01, 16'h0B0B);
    wait_cyc(20);
    chk(ev_cnt == base + 1, "R8 stop", ev_cnt, base + 1);
    chk(wr_ptr - rd_ptr == 1, "R8 no read", wr_ptr - rd_ptr, 1);
    @(negedge clk); enable = 1'b0;
    wait_cyc(2);
    enable = 1'b1;
    wait_cyc(14);
    chk(ev_cnt == base + 2, "R8 restart", ev_cnt, base + 2);
    chk(rec_addr[base + 1] == 16'h0B0B, "R8 label", rec_addr[base + 1], 16'h0B0B);

    // R9 empty flag
    chk(irq_empty == 1'b1, "R9 set", irq_empty, 1);
    pulse_clr();
    @(negedge clk);
    chk(irq_empty == 1'b0, "R9 clear", irq_empty, 0);
    push(2'b01, 16'hC0DE);
    wait_cyc(12);
    chk(irq_empty == 1'b1, "R9 reset again", irq_empty, 1);

    // R10 half flag
    chk(irq_half == 1'b0, "R10 initial", irq_half, 0);
    push(2'b00, 16'h0000);
    wait_cyc(4);
    base = ev_cnt;
    for (int k = 0; k < 5; k++) push(2'b01, 16'hD000 + k);
    wait_cyc(5);
    chk(irq_half == 1'b0, "R10 not yet", irq_half, 0);
    chk(wr_ptr - rd_ptr == 5, "R8 idle holds", wr_ptr - rd_ptr, 5);
    @(negedge clk); enable = 1'b0;
    wait_cyc(2);
    enable = 1'b1;
    wait_cyc(80);
    chk(ev_cnt == base + 5, "R10 drained", ev_cnt, base + 5);
    chk(irq_half == 1'b1, "R10 set", irq_half, 1);
    pulse_clr();
    @(negedge clk);
    chk(irq_half == 1'b0, "R10 clear", irq_half, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule